// File: doc/BRIEF.md
# Four-Way Cache Tag Directory

This block is the bookkeeping half of a small set-associative cache. It holds no data. For every line it keeps a tag, a valid flag and a dirty flag. It covers 16 sets of 4 ways over a 16-bit byte address. Each cycle it can take one access, made of an address and a write flag. It classifies the access and updates its own state. One cycle later it reports the result.

The result has four possible outcomes. An access can hit. It can fill an empty way. It can push out a clean line. It can push out a modified line, which means the caller owes memory a writeback. The response also gives the way that was used, the set, and the tag of the line that was pushed out. With these, a neighbouring controller can build the writeback address and drive the data arrays.

A 3-bit tree pseudo-LRU per set chooses the victim. It is used only when the set has no empty way.

Top module: `cache_tag_dir`

## Requirements
- R1: The address splits as follows: bits [15:8] are the tag, bits [7:4] are the set index, and bits [3:0] are the byte offset. Two accesses that differ only in the offset see the same line.
- R2: An access whose tag matches a valid way of its set reports outcome 2'b00 and that way on `rsp_way`. `rsp_victim_tag` is zero in this case.
- R3: On a miss, if the set has an invalid way, the lowest-numbered invalid way takes the new tag. The outcome is 2'b01 and `rsp_victim_tag` is zero.
- R4: On a miss into a full set, the replacement state picks the way. The new tag replaces the old one, and `rsp_victim_tag` carries the old tag. The outcome is 2'b10 if the old line was clean and 2'b11 if it was dirty.
- R5: A write that hits marks the line dirty. A read hit leaves the dirty flag unchanged.
- R6: A line filled by a read starts clean. A line filled by a write starts dirty.
- R7: Each set has 3 replacement bits: p0 (root), p1 (ways 0/1) and p2 (ways 2/3). The victim is way 0 when p0=0 and p1=0, way 1 when p0=0 and p1=1, way 2 when p0=1 and p2=0, and way 3 when p0=1 and p2=1. Every hit or fill of a way updates these bits. For way 0: p0=1 and p1=1. For way 1: p0=1 and p1=0. For way 2: p0=0 and p2=1. For way 3: p0=0 and p2=0. All bits are 0 after reset.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `acc_valid` high. Cycles without an access change no state.
- R9: Synchronous reset clears every valid flag, dirty flag and replacement bit, and deasserts `rsp_valid`.
- R10: `rsp_set` reports the set index of the access being answered. Accesses to one set leave other sets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 16 | Byte address of the access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response strobe, one cycle per access |
| rsp_outcome | output | 2 | 00 hit, 01 fill empty way, 10 clean eviction, 11 dirty eviction |
| rsp_way | output | 2 | Way that was hit or filled |
| rsp_victim_tag | output | 8 | Tag of the evicted line; zero when nothing is evicted |
| rsp_set | output | 4 | Set index of the access |

## Verification
Most internal faults show up at the ports within a few accesses to the same set. A wrong tag or valid flag turns an expected hit into a fill, or the reverse, on the next touch of that line. A dirty flag that was lost or set by mistake shows only when that line is evicted, because it flips the outcome between 2'b10 and 2'b11. A fault in the replacement bits stays hidden until the set is full. After that, the very next miss names the wrong way and the wrong victim tag. For this reason the stimulus keeps a small pool of tags over a few sets, so that sets fill, evict and refill many times.

// File: rtl/cache_dir_pkg.sv
package cache_dir_pkg;
    localparam int ADDR_W = 16;
    localparam int OFF_W  = 4;
    localparam int SET_W  = 4;
    localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
    localparam int SETS   = 1 << SET_W;
    localparam int WAYS   = 4;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int PLRU_W = WAYS - 1;

    typedef enum logic [1:0] {
        OUT_HIT         = 2'b00,
        OUT_FILL        = 2'b01,
        OUT_EVICT_CLEAN = 2'b10,
        OUT_EVICT_DIRTY = 2'b11
    } outcome_e;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            valid;
        logic [SETS-1:0][WAYS-1:0]            dirty;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
        logic [SETS-1:0][PLRU_W-1:0]          plru;
        logic                                 rsp_valid;
        outcome_e                             outcome;
        logic [WAY_W-1:0]                     way;
        logic [TAG_W-1:0]                     vtag;
        logic [SET_W-1:0]                     vset;
    } dir_state_t;
endpackage

// File: rtl/cache_dir_match.sv
module cache_dir_match
    import cache_dir_pkg::*;
(
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           hit_way_o,
    output logic                       free_o,
    output logic [WAY_W-1:0]           free_way_o
);
    logic [WAYS-1:0] hit_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_i[w] && (tags_i[w] == tag_i);
    end

    assign hit_o  = |hit_vec;
    assign free_o = ~&valid_i;

    // Descending scan so the lowest index wins.
    always_comb begin
        hit_way_o  = '0;
        free_way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w])  hit_way_o  = WAY_W'(w);
            if (!valid_i[w]) free_way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/cache_dir_plru.sv
module cache_dir_plru
    import cache_dir_pkg::*;
(
    input  logic [PLRU_W-1:0] bits_i,
    input  logic [WAY_W-1:0]  use_way_i,
    output logic [WAY_W-1:0]  victim_o,
    output logic [PLRU_W-1:0] bits_o
);
    // bit 0: root, bit 1: pair of ways 0/1, bit 2: pair of ways 2/3
    always_comb begin
        if (!bits_i[0]) victim_o = bits_i[1] ? 2'd1 : 2'd0;
        else            victim_o = bits_i[2] ? 2'd3 : 2'd2;
    end

    // Point every node on the path away from the way just used.
    always_comb begin
        bits_o = bits_i;
        unique case (use_way_i)
            2'd0: begin bits_o[0] = 1'b1; bits_o[1] = 1'b1; end
            2'd1: begin bits_o[0] = 1'b1; bits_o[1] = 1'b0; end
            2'd2: begin bits_o[0] = 1'b0; bits_o[2] = 1'b1; end
            default: begin bits_o[0] = 1'b0; bits_o[2] = 1'b0; end
        endcase
    end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
    import cache_dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              rsp_valid,
    output logic [1:0]        rsp_outcome,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [TAG_W-1:0]  rsp_victim_tag,
    output logic [SET_W-1:0]  rsp_set
);
    dir_state_t st_q, st_d;

    logic [TAG_W-1:0]  req_tag;
    logic [SET_W-1:0]  req_set;
    logic              hit, free;
    logic [WAY_W-1:0]  hit_way, free_way, victim_way, use_way;
    logic [PLRU_W-1:0] plru_next;

    assign req_tag = acc_addr[ADDR_W-1 -: TAG_W];
    assign req_set = acc_addr[OFF_W +: SET_W];

    cache_dir_match u_match (
        .valid_i    (st_q.valid[req_set]),
        .tags_i     (st_q.tag[req_set]),
        .tag_i      (req_tag),
        .hit_o      (hit),
        .hit_way_o  (hit_way),
        .free_o     (free),
        .free_way_o (free_way)
    );

    assign use_way = hit ? hit_way : (free ? free_way : victim_way);

    cache_dir_plru u_plru (
        .bits_i    (st_q.plru[req_set]),
        .use_way_i (use_way),
        .victim_o  (victim_way),
        .bits_o    (plru_next)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = acc_valid;
        if (acc_valid) begin
            st_d.way  = use_way;
            st_d.vset = req_set;
            st_d.vtag = '0;
            if (hit) begin
                st_d.outcome = OUT_HIT;
                if (acc_write) st_d.dirty[req_set][use_way] = 1'b1;
            end else begin
                if (free) begin
                    st_d.outcome = OUT_FILL;
                end else begin
                    st_d.vtag    = st_q.tag[req_set][use_way];
                    st_d.outcome = st_q.dirty[req_set][use_way] ?
                                   OUT_EVICT_DIRTY : OUT_EVICT_CLEAN;
                end
                st_d.valid[req_set][use_way] = 1'b1;
                st_d.dirty[req_set][use_way] = acc_write;
                st_d.tag[req_set][use_way]   = req_tag;
            end
            st_d.plru[req_set] = plru_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_outcome    = st_q.outcome;
    assign rsp_way        = st_q.way;
    assign rsp_victim_tag = st_q.vtag;
    assign rsp_set        = st_q.vset;
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk
    import cache_dir_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              rsp_valid,
    input logic [1:0]        rsp_outcome,
    input logic [WAY_W-1:0]  rsp_way,
    input logic [TAG_W-1:0]  rsp_victim_tag,
    input logic [SET_W-1:0]  rsp_set
);
    a_r8_rsp_follows_acc: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);

    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> !rsp_valid);

    a_r10_set_echo: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_set == $past(acc_addr[OFF_W +: SET_W]));

    a_r2_r3_no_victim_tag: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_outcome[1]) |-> rsp_victim_tag == '0);

    // R1, R2: a second access to the same line right after the first must hit
    a_r2_repeat_hits: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && $past(acc_valid) && !$past(rst) &&
         acc_addr[ADDR_W-1:OFF_W] == $past(acc_addr[ADDR_W-1:OFF_W]))
        |=> rsp_outcome == OUT_HIT);

    a_r2_repeat_same_way: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && $past(acc_valid) && !$past(rst) &&
         acc_addr[ADDR_W-1:OFF_W] == $past(acc_addr[ADDR_W-1:OFF_W]))
        |=> rsp_way == $past(rsp_way));
endmodule

bind cache_tag_dir cache_tag_dir_chk u_chk (.*);

// File: tb/cache_tag_dir_tb.sv
`timescale 1ns/1ps
module cache_tag_dir_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [15:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        rsp_valid;
    logic [1:0]  rsp_outcome;
    logic [1:0]  rsp_way;
    logic [7:0]  rsp_victim_tag;
    logic [3:0]  rsp_set;

    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    cache_tag_dir u_dut (.*);

    // reference state
    bit       m_valid [16][4];
    bit       m_dirty [16][4];
    bit [7:0] m_tag   [16][4];
    bit [2:0] m_plru  [16];

    function automatic void model_reset();
        for (int s = 0; s < 16; s++) begin
            m_plru[s] = 3'b000;
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0;
            end
        end
    endfunction

    function automatic void model_access(input bit [15:0] a, input bit wr,
                                         output bit [1:0] out, output bit [1:0] way,
                                         output bit [7:0] vt);
        bit [7:0] t = a[15:8];
        bit [3:0] s = a[7:4];
        int hw = -1, fw = -1;
        bit [2:0] p = m_plru[s];
        for (int w = 3; w >= 0; w--) begin
            if (m_valid[s][w] && m_tag[s][w] == t) hw = w;
            if (!m_valid[s][w]) fw = w;
        end
        vt = 8'h00;
        if (hw >= 0) begin
            way = 2'(hw); out = 2'b00;
            if (wr) m_dirty[s][way] = 1;
        end else begin
            if (fw >= 0) begin
                way = 2'(fw); out = 2'b01;
            end else begin
                way = (p[0] == 0) ? (p[1] ? 2'd1 : 2'd0) : (p[2] ? 2'd3 : 2'd2);
                vt  = m_tag[s][way];
                out = m_dirty[s][way] ? 2'b11 : 2'b10;
            end
            m_valid[s][way] = 1; m_dirty[s][way] = wr; m_tag[s][way] = t;
        end
        case (way)
            2'd0: begin p[0] = 1; p[1] = 1; end
            2'd1: begin p[0] = 1; p[1] = 0; end
            2'd2: begin p[0] = 0; p[2] = 1; end
            default: begin p[0] = 0; p[2] = 0; end
        endcase
        m_plru[s] = p;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge; the response is registered at the next rising edge.
    task automatic access(input bit [15:0] a, input bit wr, input string req);
        bit [1:0] eo, ew;
        bit [7:0] ev;
        string    r;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        model_access(a, wr, eo, ew, ev);
        @(posedge clk);
        #1;
        if (req.len() != 0) r = req;
        else if (eo == 2'b00) r = "R2";
        else if (eo == 2'b01) r = "R3";
        else r = "R4";
        check(rsp_valid == 1'b1, "R8", "rsp_valid", rsp_valid, 1);
        check(rsp_outcome == eo, r, "outcome", rsp_outcome, eo);
        check(rsp_way == ew, (eo[1] ? "R7" : r), "way", rsp_way, ew);
        check(rsp_victim_tag == ev, r, "victim tag", rsp_victim_tag, ev);
        check(rsp_set == a[7:4], "R10", "set", rsp_set, a[7:4]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            @(posedge clk);
            #1;
            check(rsp_valid == 1'b0, "R8", "rsp_valid idle", rsp_valid, 0);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_valid = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #1;
        check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : stim
        bit [7:0] pool [8];
        void'($urandom(32'd4242));
        do_reset();
        idle(2);                                  // R8 no access, no response
        // R3: fill set 0xC in ascending way order
        access(16'hABCD, 0, "R3");
        access(16'hABC0, 0, "R1");                // offset change still hits
        access(16'hABC7, 1, "R5");                // write hit -> dirty
        access(16'hACCD, 0, "R3");
        access(16'hADCD, 1, "R6");                // write fill -> dirty
        access(16'hAECD, 0, "R3");
        access(16'h1120, 0, "R10");               // other set untouched
        access(16'hABCD, 0, "R2");
        access(16'hADC1, 0, "R2");
        idle(1);
        // R7/R4: full set, victim from replacement tree
        access(16'hAFCD, 0, "R4");                // clean victim
        access(16'hACC3, 0, "R4");
        access(16'hEAC2, 0, "R4");                // dirty victims appear here
        access(16'h77C0, 0, "R4");
        access(16'h66C0, 1, "R6");
        access(16'h55C0, 0, "R4");
        access(16'h1120, 0, "R10");               // set 2 still holds its line
        // R9: reset forgets everything
        do_reset();
        access(16'hABCD, 0, "R9");                // must be fill into way 0
        // random phase
        for (int i = 0; i < 8; i++) pool[i] = 8'($urandom);
        for (int i = 0; i < 4000; i++) begin
            bit [15:0] a;
            a[15:8] = pool[$urandom % 8];
            a[7:4]  = 4'($urandom % 3) + 4'd5;
            a[3:0]  = 4'($urandom);
            if ($urandom % 7 == 0) idle(1);
            access(a, 1'($urandom % 3 == 0), "");
        end
        idle(1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule